// File: doc/BRIEF.md
# Pseudo-Random Background Check Scheduler

This block decides when the background integrity and consistency checks of a storage controller run. Each check type has its own period value. When that value is non-zero, a countdown is loaded from a 40-bit linear feedback shift register masked by the period, so the interval is a random draw bounded by the programmed range. When the countdown reaches zero, a request for that check type is queued. Software can also queue a one-off check of either type through a trigger register. The block does not perform any check itself.

Queued requests are sent to the checker logic as single-cycle pulses, and only one batch of checks is outstanding at a time. The checker answers with an acknowledge. A programmable cycle timeout guards every outstanding batch. If it expires, or if the sequencing state machine reaches an illegal encoding, the block sets a sticky error, raises a fatal alert and stops issuing requests until reset. The period and timeout values sit behind one write-once lock, and the trigger register sits behind a second one.

Top module: `bgchk_timer`

## Requirements
- R1: The random source is a 40-bit Fibonacci shift register loaded with a non-zero seed (default 0x5AC3E19D27) at reset. It advances every clock: the new state is the old state shifted left by one, with bit 0 set to the XOR of old bits 39, 37, 20 and 18.
- R2: For a check type with period P ≠ 0, the countdown is loaded with (LFSR AND {P, 8'hFF}) in the cycle after P becomes non-zero. It is reloaded with a fresh draw when a check that included that type is acknowledged. Otherwise it decrements by one per cycle, and on reaching zero it queues exactly one request of that type.
- R3: A period of zero (the reset value) stops the timer of that type, so the timer queues no requests of that type.
- R4: Register writes use reg_sel_i codes 0 = integrity period, 1 = consistency period, 2 = timeout, 3 = configuration lock, 4 = trigger lock, 5 = trigger. Codes 6 and 7 are ignored. A trigger write queues an integrity request for data bit 0 and a consistency request for data bit 1. When no check is outstanding, all queued requests are issued together as one-cycle pulses on integ_req_o and cons_req_o.
- R5: The trigger lock reads back on trig_open_o. It resets to 1 and is cleared only by a code-4 write with data bit 0 equal to 0. Once it is cleared, trigger writes have no effect.
- R6: The configuration lock reads back on cfg_open_o. It resets to 1 and is cleared by a code-3 write with data bit 0 equal to 0. Once it is cleared, writes to the periods and the timeout are ignored.
- R7: pending_o is 1 exactly while a request is queued or a batch is outstanding.
- R8: check_ack_i ends the outstanding batch in the cycle it is sampled. An acknowledge sampled while no batch is outstanding has no effect. A new batch is not issued before the current one is acknowledged.
- R9: With timeout T ≠ 0, if no acknowledge is sampled during the first T cycles after the request pulse, timeout_err_o and fatal_alert_o rise in the next cycle. With T = 0 the timeout never fires.
- R10: Errors are sticky until reset. After a fatal error no further request pulses are issued.
- R11: An illegal state encoding of the sequencer sets fsm_err_o and fatal_alert_o. No such error occurs in normal operation.
- R12: Out of reset no requests, pending flag or errors are asserted, and both locks are open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 3 | Register select code (see R4) |
| reg_wdata_i | input | 32 | Register write data |
| check_ack_i | input | 1 | Checker acknowledge that the outstanding batch has finished |
| integ_req_o | output | 1 | Integrity check request pulse |
| cons_req_o | output | 1 | Consistency check request pulse |
| pending_o | output | 1 | A check is queued or outstanding |
| timeout_err_o | output | 1 | Sticky check timeout error |
| fsm_err_o | output | 1 | Sticky illegal-state error |
| fatal_alert_o | output | 1 | Fatal alert, OR of both errors |
| cfg_open_o | output | 1 | Period/timeout write enable state |
| trig_open_o | output | 1 | Trigger write enable state |

## Verification
The scheduler is exercised with single and double software triggers, with a second trigger arriving while a batch is still outstanding, and with acknowledges sent while nothing is outstanding. These cases separate queuing from issuing and show that batches never overlap. Long runs with small non-zero periods compare every pulse cycle against an independently computed shift-register sequence, which catches wrong taps, a wrong mask shape or a wrong reload point. Turning a period off, locking each lock, acknowledging exactly at the last permitted cycle, and withholding the acknowledge then tell the ignore paths and the timeout boundary apart from the terminal error behaviour.

// File: rtl/bgchk_pkg.sv
package bgchk_pkg;
  // number of check kinds: index 0 integrity, index 1 consistency
  localparam int unsigned NCHK = 2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_WAIT = 2'b01,
    ST_DEAD = 2'b10
  } seq_e;

  typedef enum logic [2:0] {
    SEL_PER_INTEG = 3'd0,
    SEL_PER_CONS  = 3'd1,
    SEL_TIMEOUT   = 3'd2,
    SEL_CFG_LOCK  = 3'd3,
    SEL_TRIG_LOCK = 3'd4,
    SEL_TRIGGER   = 3'd5
  } sel_e;
endpackage

// File: rtl/bgchk_lfsr.sv
module bgchk_lfsr #(
  parameter int unsigned W    = 40,
  parameter logic [W-1:0] TAPS = 40'hA0_0014_0000,
  parameter logic [W-1:0] SEED = 40'h5A_C3E1_9D27
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  output logic [W-1:0] state_o
);
  // an all-zero seed would lock the register; substitute 1
  localparam logic [W-1:0] SEED_SAFE = (SEED == '0) ? W'(1) : SEED;

  function automatic logic [W-1:0] step(input logic [W-1:0] s);
    return {s[W-2:0], ^(s & TAPS)};
  endfunction

  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= SEED_SAFE;
    else         q <= step(q);
  end

  assign state_o = q;
endmodule

// File: rtl/bgchk_countdown.sv
module bgchk_countdown #(
  parameter int unsigned CW = 40,
  parameter int unsigned PW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [PW-1:0] period_i,
  input  logic [CW-1:0] lfsr_i,
  input  logic          done_i,
  output logic          fire_o
);
  localparam int unsigned LOW_W = CW - PW;

  // R2: interval draw, period shifted up with low bits forced high
  function automatic logic [CW-1:0] draw(input logic [CW-1:0] r, input logic [PW-1:0] p);
    return r & {p, {LOW_W{1'b1}}};
  endfunction

  logic [CW-1:0] cnt_q;
  logic          loaded_q;
  logic          wait_q;
  logic          enabled;

  assign enabled = (period_i != '0);
  assign fire_o  = enabled && loaded_q && (cnt_q == '0) && !wait_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      loaded_q <= 1'b0;
      wait_q   <= 1'b0;
    end else if (!enabled) begin
      cnt_q    <= '0;
      loaded_q <= 1'b0;
      wait_q   <= 1'b0;
    end else if (!loaded_q) begin
      cnt_q    <= draw(lfsr_i, period_i);
      loaded_q <= 1'b1;
    end else if (done_i) begin
      cnt_q    <= draw(lfsr_i, period_i);
      wait_q   <= 1'b0;
    end else if (cnt_q != '0) begin
      cnt_q    <= cnt_q - CW'(1);
    end else if (!wait_q) begin
      wait_q   <= 1'b1;
    end
  end
endmodule

// File: rtl/bgchk_seq.sv
module bgchk_seq
  import bgchk_pkg::*;
#(
  parameter int unsigned TW = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NCHK-1:0] arm_i,
  input  logic [NCHK-1:0] soft_i,
  input  logic            ack_i,
  input  logic [TW-1:0]   timeout_i,
  output logic [NCHK-1:0] req_o,
  output logic [NCHK-1:0] done_o,
  output logic            pending_o,
  output logic            tmo_fire_o,
  output logic            tmo_err_o,
  output logic            fsm_err_o
);
  // R9: expiry once the waited cycles reach the limit; zero limit never expires
  function automatic logic tmo_expired(input logic [TW-1:0] cnt, input logic [TW-1:0] lim);
    return (lim != '0) && (({1'b0, cnt} + (TW+1)'(1)) >= {1'b0, lim});
  endfunction

  seq_e            state_q;
  logic [NCHK-1:0] req_q;
  logic [NCHK-1:0] issued_q;
  logic [TW-1:0]   tmo_q;
  logic            tmo_err_q;
  logic            fsm_err_q;
  logic            issue;
  logic            complete;

  assign issue      = (state_q == ST_IDLE) && (req_q != '0);
  assign complete   = (state_q == ST_WAIT) && ack_i;
  assign tmo_fire_o = (state_q == ST_WAIT) && !ack_i && tmo_expired(tmo_q, timeout_i);
  assign req_o      = issue ? req_q : '0;
  assign done_o     = complete ? issued_q : '0;
  assign pending_o  = (state_q == ST_WAIT) || (req_q != '0);
  assign tmo_err_o  = tmo_err_q;
  assign fsm_err_o  = fsm_err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      req_q     <= '0;
      issued_q  <= '0;
      tmo_q     <= '0;
      tmo_err_q <= 1'b0;
      fsm_err_q <= 1'b0;
    end else begin
      req_q <= (req_q & ~req_o) | arm_i | soft_i;
      case (state_q)
        ST_IDLE: begin
          if (issue) begin
            state_q  <= ST_WAIT;
            issued_q <= req_q;
            tmo_q    <= '0;
          end
        end
        ST_WAIT: begin
          if (ack_i) begin
            state_q <= ST_IDLE;
          end else if (tmo_fire_o) begin
            state_q   <= ST_DEAD;
            tmo_err_q <= 1'b1;
          end else begin
            tmo_q <= tmo_q + TW'(1);
          end
        end
        ST_DEAD: state_q <= ST_DEAD;
        default: begin
          state_q   <= ST_DEAD;
          fsm_err_q <= 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/bgchk_timer.sv
module bgchk_timer
  import bgchk_pkg::*;
#(
  parameter int unsigned       REG_W     = 32,
  parameter logic [REG_W+7:0]  LFSR_TAPS = 40'hA0_0014_0000,
  parameter logic [REG_W+7:0]  LFSR_SEED = 40'h5A_C3E1_9D27
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [2:0]       reg_sel_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  input  logic             check_ack_i,
  output logic             integ_req_o,
  output logic             cons_req_o,
  output logic             pending_o,
  output logic             timeout_err_o,
  output logic             fsm_err_o,
  output logic             fatal_alert_o,
  output logic             cfg_open_o,
  output logic             trig_open_o
);
  localparam int unsigned LFSR_W = REG_W + 8;

  logic [LFSR_W-1:0] lfsr_w;
  logic [REG_W-1:0]  timeout_q;
  logic              cfg_open_q;
  logic              trig_open_q;
  logic [NCHK-1:0]   soft_w;
  logic [NCHK-1:0]   tmr_fire_w;
  logic [NCHK-1:0]   req_w;
  logic [NCHK-1:0]   done_w;
  logic              tmo_fire_w;
  logic              tmo_err_w;
  logic              fsm_err_w;
  logic              wr_cfg;

  assign wr_cfg = reg_we_i && cfg_open_q;
  assign soft_w = (reg_we_i && reg_sel_i == SEL_TRIGGER && trig_open_q)
                ? reg_wdata_i[NCHK-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      timeout_q   <= '0;
      cfg_open_q  <= 1'b1;
      trig_open_q <= 1'b1;
    end else begin
      if (wr_cfg && reg_sel_i == SEL_TIMEOUT) timeout_q <= reg_wdata_i;
      if (reg_we_i && reg_sel_i == SEL_CFG_LOCK && !reg_wdata_i[0]) cfg_open_q <= 1'b0;
      if (reg_we_i && reg_sel_i == SEL_TRIG_LOCK && !reg_wdata_i[0]) trig_open_q <= 1'b0;
    end
  end

  bgchk_lfsr #(.W(LFSR_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)) u_lfsr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .state_o (lfsr_w)
  );

  // one period register and countdown per check kind; select code = kind index
  for (genvar k = 0; k < NCHK; k++) begin : g_kind
    logic [REG_W-1:0] per_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) per_q <= '0;
      else if (wr_cfg && reg_sel_i == 3'(k)) per_q <= reg_wdata_i;
    end
    bgchk_countdown #(.CW(LFSR_W), .PW(REG_W)) u_tmr (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .period_i (per_q),
      .lfsr_i   (lfsr_w),
      .done_i   (done_w[k]),
      .fire_o   (tmr_fire_w[k])
    );
  end

  bgchk_seq #(.TW(REG_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .arm_i      (tmr_fire_w),
    .soft_i     (soft_w),
    .ack_i      (check_ack_i),
    .timeout_i  (timeout_q),
    .req_o      (req_w),
    .done_o     (done_w),
    .pending_o  (pending_o),
    .tmo_fire_o (tmo_fire_w),
    .tmo_err_o  (tmo_err_w),
    .fsm_err_o  (fsm_err_w)
  );

  assign integ_req_o   = req_w[0];
  assign cons_req_o    = req_w[1];
  assign timeout_err_o = tmo_err_w;
  assign fsm_err_o     = fsm_err_w;
  assign fatal_alert_o = tmo_err_w | fsm_err_w;
  assign cfg_open_o    = cfg_open_q;
  assign trig_open_o   = trig_open_q;
endmodule

// File: rtl/bgchk_timer_chk.sv
module bgchk_timer_chk #(
  parameter int unsigned REG_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             integ_req_o,
  input logic             cons_req_o,
  input logic             pending_o,
  input logic             fatal_alert_o,
  input logic             cfg_open_o,
  input logic             trig_open_o,
  input logic [REG_W-1:0] timeout_q,
  input logic             tmo_fire_w,
  input logic [1:0]       tmr_fire_w
);
  p_fire_queues_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmr_fire_w != 2'b00) |=> pending_o);

  p_pulse_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (integ_req_o || cons_req_o) |=> !(integ_req_o || cons_req_o));

  p_trig_lock_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trig_open_o |=> !trig_open_o);

  p_cfg_lock_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_open_o |=> !cfg_open_o);

  p_pend_on_req_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (integ_req_o || cons_req_o) |-> pending_o);

  p_tmo_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (timeout_q == '0) |-> !tmo_fire_w);

  p_tmo_alert_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_fire_w |=> fatal_alert_o);

  p_alert_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fatal_alert_o |=> fatal_alert_o);

  p_quiet_dead_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fatal_alert_o |-> !(integ_req_o || cons_req_o));
endmodule

bind bgchk_timer bgchk_timer_chk #(.REG_W(REG_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .integ_req_o   (integ_req_o),
  .cons_req_o    (cons_req_o),
  .pending_o     (pending_o),
  .fatal_alert_o (fatal_alert_o),
  .cfg_open_o    (cfg_open_o),
  .trig_open_o   (trig_open_o),
  .timeout_q     (timeout_q),
  .tmo_fire_w    (tmo_fire_w),
  .tmr_fire_w    (tmr_fire_w)
);

// File: tb/bgchk_timer_bench.sv
`timescale 1ns/1ps
module bgchk_timer_bench;
  localparam longint MASK40 = 64'hFF_FFFF_FFFF;
  localparam longint TAPS40 = 64'hA0_0014_0000;
  localparam longint SEED40 = 64'h5A_C3E1_9D27;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_sel = 3'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic        auto_ack_pulse = 1'b0;
  logic        man_ack = 1'b0;
  wire         ack = auto_ack_pulse | man_ack;
  logic integ_req, cons_req, pending, terr, ferr, alert, cfg_open, trig_open;

  always #5 clk = ~clk;

  bgchk_timer u_bgchk_timer (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_sel_i(reg_sel),
    .reg_wdata_i(reg_wdata), .check_ack_i(ack), .integ_req_o(integ_req),
    .cons_req_o(cons_req), .pending_o(pending), .timeout_err_o(terr),
    .fsm_err_o(ferr), .fatal_alert_o(alert), .cfg_open_o(cfg_open),
    .trig_open_o(trig_open)
  );

  int n_chk = 0;
  int n_bad = 0;
  int n_int = 0;
  int n_con = 0;
  bit auto_on = 1'b0;
  int ack_delay = 2;
  int ack_cnt = 0;
  bit finished = 1'b0;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  longint m_lfsr, m_tmo, m_tcnt;
  longint m_per [2];
  longint m_cnt [2];
  bit     m_loaded [2];
  bit     m_wait [2];
  bit     m_cfg_open, m_trig_open, m_terr, m_live;
  bit [1:0] m_req, m_issued;
  int     m_state;  // 0 idle, 1 waiting on checker, 2 dead
  bit     b_issue, b_done;
  bit [1:0] b_fire, b_soft, b_nreq;

  function automatic longint lfsr_adv(input longint v);
    return ((v << 1) & MASK40) | longint'($countones(v & TAPS40) % 2);
  endfunction

  function automatic longint pick(input longint v, input longint per);
    return v & ((per * 256) + 255);
  endfunction

  function automatic bit m_issue_now();
    return (m_state == 0) && (m_req != 2'b00);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_lfsr = SEED40; m_tmo = 0; m_tcnt = 0;
      for (int k = 0; k < 2; k++) begin
        m_per[k] = 0; m_cnt[k] = 0; m_loaded[k] = 0; m_wait[k] = 0;
      end
      m_cfg_open = 1; m_trig_open = 1; m_terr = 0; m_req = 0; m_issued = 0;
      m_state = 0; m_live = 0;
    end else begin
      b_issue = m_issue_now();
      b_done  = (m_state == 1) && ack;
      for (int k = 0; k < 2; k++)
        b_fire[k] = (m_per[k] != 0) && m_loaded[k] && (m_cnt[k] == 0) && !m_wait[k];
      b_soft = (reg_we && reg_sel == 3'd5 && m_trig_open) ? reg_wdata[1:0] : 2'b00;
      for (int k = 0; k < 2; k++) begin
        if (m_per[k] == 0) begin
          m_cnt[k] = 0; m_loaded[k] = 0; m_wait[k] = 0;
        end else if (!m_loaded[k]) begin
          m_cnt[k] = pick(m_lfsr, m_per[k]); m_loaded[k] = 1;
        end else if (b_done && m_issued[k]) begin
          m_cnt[k] = pick(m_lfsr, m_per[k]); m_wait[k] = 0;
        end else if (m_cnt[k] != 0) begin
          m_cnt[k] = m_cnt[k] - 1;
        end else if (!m_wait[k]) begin
          m_wait[k] = 1;
        end
      end
      b_nreq = (b_issue ? 2'b00 : m_req) | b_fire | b_soft;
      if (m_state == 0) begin
        if (b_issue) begin m_state = 1; m_issued = m_req; m_tcnt = 0; end
      end else if (m_state == 1) begin
        if (ack) m_state = 0;
        else if (m_tmo != 0 && m_tcnt + 1 >= m_tmo) begin m_state = 2; m_terr = 1; end
        else m_tcnt = m_tcnt + 1;
      end
      m_req = b_nreq;
      if (reg_we) begin
        case (reg_sel)
          3'd0: if (m_cfg_open) m_per[0] = reg_wdata;
          3'd1: if (m_cfg_open) m_per[1] = reg_wdata;
          3'd2: if (m_cfg_open) m_tmo = reg_wdata;
          3'd3: if (!reg_wdata[0]) m_cfg_open = 0;
          3'd4: if (!reg_wdata[0]) m_trig_open = 0;
          default: ;
        endcase
      end
      m_lfsr = lfsr_adv(m_lfsr);
      m_live = 1;
    end
  end

  // ---------------- per-cycle comparison and checker responder ----------------
  always @(negedge clk) begin
    if (m_live) begin
      chk("R1/R2/R4", "integ_req", integ_req, m_issue_now() && m_req[0]);
      chk("R1/R2/R4", "cons_req", cons_req, m_issue_now() && m_req[1]);
      chk("R7", "pending", pending, (m_state == 1) || (m_req != 0));
      chk("R9", "timeout_err", terr, m_terr);
      chk("R11", "fsm_err", ferr, 0);
      chk("R10", "fatal_alert", alert, m_terr);
      chk("R6", "cfg_open", cfg_open, m_cfg_open);
      chk("R5", "trig_open", trig_open, m_trig_open);
      if (integ_req) n_int++;
      if (cons_req) n_con++;
    end
    auto_ack_pulse = 1'b0;
    if (ack_cnt > 0) begin
      ack_cnt--;
      if (ack_cnt == 0) auto_ack_pulse = 1'b1;
    end
    if (auto_on && m_live && m_issue_now()) ack_cnt = ack_delay;
  end

  // ---------------- stimulus ----------------
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    idle(3);
    // R12 reset state
    chk("R12", "integ_req@rst", integ_req, 0);
    chk("R12", "cons_req@rst", cons_req, 0);
    chk("R12", "pending@rst", pending, 0);
    chk("R12", "alert@rst", alert, 0);
    chk("R12", "cfg_open@rst", cfg_open, 1);
    chk("R12", "trig_open@rst", trig_open, 1);
    rst_n = 1'b1;
    idle(2);
  endtask

  int base_i, base_c;

  initial begin
    do_reset();

    // R4: single and double software triggers
    auto_on = 1'b1; ack_delay = 3;
    wr(3'd5, 32'h1); idle(10);
    wr(3'd5, 32'h3); idle(10);
    // R8: second trigger while a batch is outstanding must wait
    ack_delay = 6;
    base_c = n_con;
    wr(3'd5, 32'h1); wr(3'd5, 32'h2); idle(20);
    chk("R8", "cons pulses after overlap", n_con - base_c, 1);
    // R8: acknowledge with nothing outstanding
    @(negedge clk); man_ack = 1'b1; @(negedge clk); man_ack = 1'b0;
    idle(2);
    chk("R8", "pending after stray ack", pending, 0);
    // codes 6 and 7 ignored
    wr(3'd6, 32'h3); wr(3'd7, 32'h0); idle(4);
    chk("R4", "pending after unused codes", pending, 0);

    // R9 boundary: acknowledge in the last permitted cycle
    wr(3'd2, 32'd4); ack_delay = 4;
    wr(3'd5, 32'h1); idle(20);
    chk("R9", "no timeout at boundary", terr, 0);
    ack_delay = 2;

    // R5: trigger lock
    wr(3'd4, 32'h1); idle(1);
    chk("R5", "lock kept on bit0=1", trig_open, 1);
    wr(3'd4, 32'h0); idle(1);
    chk("R5", "lock cleared", trig_open, 0);
    base_i = n_int; base_c = n_con;
    wr(3'd5, 32'h3); idle(10);
    chk("R5", "locked trigger pulses", (n_int - base_i) + (n_con - base_c), 0);

    // R1/R2: timer-driven checks
    wr(3'd0, 32'd1); wr(3'd1, 32'd2);
    base_i = n_int; base_c = n_con;
    idle(4000);
    chk("R2", "integ timer pulses >=3", (n_int - base_i) >= 3, 1);
    chk("R2", "cons timer pulses >=3", (n_con - base_c) >= 3, 1);

    // R3: period zero stops the integrity timer
    wr(3'd0, 32'd0); idle(50);
    base_i = n_int;
    idle(1500);
    chk("R3", "integ pulses with zero period", n_int - base_i, 0);

    // R6: configuration lock
    wr(3'd3, 32'h0); idle(1);
    chk("R6", "cfg lock cleared", cfg_open, 0);
    wr(3'd1, 32'd0); wr(3'd2, 32'd1); wr(3'd0, 32'd1);
    base_i = n_int; base_c = n_con;
    idle(3000);
    chk("R6", "cons keeps running", (n_con - base_c) > 0, 1);
    chk("R6", "integ stays off", n_int - base_i, 0);
    chk("R6", "timeout write ignored", terr, 0);

    // R9/R10: withheld acknowledge
    auto_on = 1'b0;
    do_reset();
    wr(3'd0, 32'd1); wr(3'd2, 32'd3);
    wr(3'd5, 32'h2); idle(10);
    chk("R9", "timeout error", terr, 1);
    chk("R10", "fatal alert", alert, 1);
    base_i = n_int; base_c = n_con;
    wr(3'd5, 32'h3);
    idle(2000);
    chk("R10", "pulses after fatal", (n_int - base_i) + (n_con - base_c), 0);
    chk("R10", "alert sticky", alert, 1);
    chk("R11", "fsm error absent", ferr, 0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL R8 watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule